// File: doc/BRIEF.md
# Four-Phase Power-Clock Sequencer

This block produces four digital stand-ins for a trapezoidal AC supply. They are meant for cycle-accurate logic modelling of a pipelined dual-rail datapath. One system clock drives an interval counter and a quarter counter. Each of the four outputs is a phase that lags the previous one by one quarter of the period.

Every phase steps through four intervals of equal length: evaluate, hold, recover and idle. Each phase is reported as a 2-bit level code:

- hold is high.
- idle is low.
- Both ramp intervals, evaluate and recover, share one intermediate code.

Per-phase flags mark evaluate (where a downstream stage samples its input) and hold (where it keeps its output). A synchronous active-low reset restarts the sequence. An enable input freezes it.

Top module: `pcs_power_clock_seq`

## Requirements
- R1: Phase k (k = 1..3) lags phase k-1 by one interval. Phase k enters evaluate exactly INTERVAL_CYC enabled cycles after phase k-1 does, so `hold_o` always equals `eval_o` rotated right by one bit.
- R2: Every phase visits its intervals in the fixed order evaluate, hold, recover, idle, and then returns to evaluate.
- R3: The level of phase k appears on `pc_level_o[2k+1:2k]`. The hold interval is coded 2'b11 and the idle interval is coded 2'b00.
- R4: The evaluate and recover intervals are both coded 2'b01.
- R5: Each interval lasts INTERVAL_CYC enabled clock cycles. The default is 25, which gives a period of 100 cycles.
- R6: `eval_o[k]` is high exactly when phase k is in evaluate, and `hold_o[k]` is high exactly when phase k is in hold. Each vector has exactly one bit set at all times.
- R7: When `rst_n` is low at a rising edge, the next state has phase 0 at the first cycle of evaluate. In that state phases 1, 2 and 3 are in idle, recover and hold, which makes `pc_level_o` = 8'b11_01_00_01, `eval_o` = 4'b0001 and `hold_o` = 4'b1000.
- R8: While `en_i` is low, no state advances. All outputs keep their values, and the interval resumes from where it stopped.
- R9: Reset takes effect even when `en_i` is low in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Advance enable; low freezes the sequence |
| pc_level_o | output | 8 | Level code of phase k at bits [2k+1:2k] |
| eval_o | output | 4 | One-hot flag: phase k in evaluate |
| hold_o | output | 4 | One-hot flag: phase k in hold |

## Verification
Three functions can fall in the same cycle: reset, a low enable, and the last count of an interval. The random stream drops enable about a quarter of the time and pulses reset about one cycle in a hundred, so these collide at interval boundaries as well as mid-interval. A bench model gives reset priority, then enable. Every output is compared with that model on each cycle. A directed case also drives reset while enable is low in the middle of a run, and expects the reset state rather than a frozen one.

// File: rtl/pcs_pkg.sv
// Package: shared types and codes for the four-phase power-clock sequencer.
// Assumes exactly four phases, one per quarter of the power-clock period.
package pcs_pkg;

    localparam int NUM_PHASES = 4;

    // Interval index inside one period, in the order every phase visits them.
    typedef enum logic [1:0] {
        IV_EVAL    = 2'd0,
        IV_HOLD    = 2'd1,
        IV_RECOVER = 2'd2,
        IV_IDLE    = 2'd3
    } interval_e;

    typedef logic [1:0] level_t;

    localparam level_t LVL_LOW  = 2'b00;
    localparam level_t LVL_RAMP = 2'b01;
    localparam level_t LVL_HIGH = 2'b11;

    // Maps an interval to its level code; both ramp intervals share one code.
    function automatic level_t level_of(interval_e iv);
        case (iv)
            IV_HOLD: return LVL_HIGH;
            IV_IDLE: return LVL_LOW;
            default: return LVL_RAMP;
        endcase
    endfunction

endpackage

// File: rtl/pcs_interval_timer.sv
// Interval timer: counts enabled cycles inside one interval and flags its last one.
// Assumes INTERVAL_CYC >= 1; with 1 every enabled cycle ends an interval.
module pcs_interval_timer #(
    parameter int INTERVAL_CYC = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic step_o
);

    localparam int CW = (INTERVAL_CYC > 1) ? $clog2(INTERVAL_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(INTERVAL_CYC - 1);

    logic [CW-1:0] cnt_q;
    logic          at_last;

    // Detect the final cycle of the current interval.
    always_comb begin
        at_last = (cnt_q == LAST);
        step_o  = en_i && at_last;
    end

    // Count enabled cycles, wrapping at the interval end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (en_i) begin
            cnt_q <= at_last ? '0 : cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/pcs_quarter_ring.sv
// Quarter ring: tracks which quarter of the period is current.
// Assumes the step input is high for one cycle per interval end.
module pcs_quarter_ring (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       step_i,
    output logic [1:0] qtr_o
);

    logic [1:0] qtr_q;

    // Advance the quarter index modulo four on each interval end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            qtr_q <= 2'd0;
        end else if (step_i) begin
            qtr_q <= qtr_q + 2'd1;
        end
    end

    // Expose the quarter index.
    always_comb qtr_o = qtr_q;

endmodule

// File: rtl/pcs_phase_encoder.sv
// Phase encoder: turns the global quarter into one phase's level and flags.
// Assumes the phase lags phase 0 by OFFSET quarters (0..3).
module pcs_phase_encoder
    import pcs_pkg::*;
#(
    parameter int OFFSET = 0
) (
    input  logic [1:0] qtr_i,
    output level_t     level_o,
    output logic       eval_o,
    output logic       hold_o
);

    localparam logic [1:0] OFS = OFFSET[1:0];

    interval_e iv;

    // Compute this phase's interval and decode level and flags.
    always_comb begin
        iv      = interval_e'(qtr_i - OFS);
        level_o = level_of(iv);
        eval_o  = (iv == IV_EVAL);
        hold_o  = (iv == IV_HOLD);
    end

endmodule

// File: rtl/pcs_power_clock_seq.sv
// Top: four-phase power-clock sequencer with three-level phase codes.
// Assumes a single clock domain, synchronous active-low reset, and an enable
// that pauses the whole sequence without losing the position in an interval.
module pcs_power_clock_seq
    import pcs_pkg::*;
#(
    parameter int INTERVAL_CYC = 25
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en_i,
    output logic [2*NUM_PHASES-1:0] pc_level_o,
    output logic [NUM_PHASES-1:0]   eval_o,
    output logic [NUM_PHASES-1:0]   hold_o
);

    logic       step;
    logic [1:0] qtr;

    pcs_interval_timer #(
        .INTERVAL_CYC(INTERVAL_CYC)
    ) i_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (en_i),
        .step_o(step)
    );

    pcs_quarter_ring i_ring (
        .clk   (clk),
        .rst_n (rst_n),
        .step_i(step),
        .qtr_o (qtr)
    );

    for (genvar k = 0; k < NUM_PHASES; k++) begin : g_phase
        level_t lvl;

        pcs_phase_encoder #(
            .OFFSET(k)
        ) i_enc (
            .qtr_i  (qtr),
            .level_o(lvl),
            .eval_o (eval_o[k]),
            .hold_o (hold_o[k])
        );

        // Place this phase's level in its slice of the output bus.
        always_comb pc_level_o[2*k +: 2] = lvl;
    end

endmodule

// File: rtl/pcs_seq_checker.sv
// Checker: temporal properties of the power-clock sequencer, bound to the top.
module pcs_seq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       en_i,
    input logic [7:0] pc_level_o,
    input logic [3:0] eval_o,
    input logic [3:0] hold_o
);

    logic armed = 1'b0;

    // Mark that at least one clock edge has passed.
    always_ff @(posedge clk) armed <= 1'b1;

    AST_ONE_EVAL: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(eval_o) == 1); // R6
    AST_ONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(hold_o) == 1); // R6
    AST_HOLD_TRAILS_EVAL: assert property (@(posedge clk) disable iff (!rst_n)
        hold_o == {eval_o[0], eval_o[3:1]}); // R1
    AST_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> ($stable(pc_level_o) && $stable(eval_o) && $stable(hold_o))); // R8
    AST_RESET_STATE: assert property (@(posedge clk) disable iff (!armed)
        $past(!rst_n) |-> (pc_level_o == 8'b11_01_00_01 && eval_o == 4'b0001
                           && hold_o == 4'b1000)); // R7
    AST_EVAL_THEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        ($past(rst_n) && $fell(eval_o[0])) |-> hold_o[0]); // R2

    for (genvar k = 0; k < 4; k++) begin : g_lvl
        AST_EVAL_RAMP: assert property (@(posedge clk) disable iff (!rst_n)
            eval_o[k] |-> pc_level_o[2*k +: 2] == 2'b01); // R4
        AST_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
            hold_o[k] |-> pc_level_o[2*k +: 2] == 2'b11); // R3
    end

endmodule

bind pcs_power_clock_seq pcs_seq_checker i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (en_i),
    .pc_level_o(pc_level_o),
    .eval_o    (eval_o),
    .hold_o    (hold_o)
);

// File: tb/test_pcs_power_clock_seq.sv
`timescale 1ns/1ps
module test_pcs_power_clock_seq;

    localparam int L = 25;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_i = 1'b0;
    logic [7:0] pc_level_o;
    logic [3:0] eval_o;
    logic [3:0] hold_o;

    int checks = 0;
    int errors = 0;
    int m_cnt = 0;
    int m_q = 0;
    bit live = 1'b0;
    bit done = 1'b0;

    pcs_power_clock_seq #(.INTERVAL_CYC(L)) i_pcs_power_clock_seq (
        .clk(clk), .rst_n(rst_n), .en_i(en_i),
        .pc_level_o(pc_level_o), .eval_o(eval_o), .hold_o(hold_o)
    );

    always #2.5 clk = ~clk;

    // Interval of phase k for quarter q: 0 eval, 1 hold, 2 recover, 3 idle.
    function automatic int iv_of(int q, int k);
        return (q - k + 4) % 4;
    endfunction

    function automatic logic [1:0] code_of(int iv);
        return (iv == 1) ? 2'b11 : (iv == 3) ? 2'b00 : 2'b01;
    endfunction

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // Reference model: reset first, then enable, as the requirements order them.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt <= 0; m_q <= 0;
        end else if (en_i) begin
            if (m_cnt == L - 1) begin
                m_cnt <= 0; m_q <= (m_q + 1) % 4;
            end else begin
                m_cnt <= m_cnt + 1;
            end
        end
    end

    // Per-cycle comparison of every output with the model.
    always @(negedge clk) begin
        if (live) begin
            logic [3:0] ee, eh;
            ee = '0; eh = '0;
            for (int k = 0; k < 4; k++) begin
                int iv;
                iv = iv_of(m_q, k);
                chk((iv == 1 || iv == 3) ? "R3 level" : "R4 level",
                    {6'b0, pc_level_o[2*k +: 2]}, {6'b0, code_of(iv)});
                ee[k] = (iv == 0);
                eh[k] = (iv == 1);
            end
            chk("R6 eval flags", {4'b0, eval_o}, {4'b0, ee});
            chk("R6 hold flags", {4'b0, hold_o}, {4'b0, eh});
        end
    end

    task automatic cyc(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        logic [7:0] snap;
        void'($urandom(32'd1234));
        cyc(2);
        live = 1'b1;
        cyc(1);
        // R7: reset state
        chk("R7 reset level", pc_level_o, 8'b11_01_00_01);
        chk("R7 reset eval", {4'b0, eval_o}, 8'b0001);
        chk("R7 reset hold", {4'b0, hold_o}, 8'b1000);
        rst_n = 1'b1; en_i = 1'b1;
        cyc(L - 1);
        // R5: evaluate still on after L-1 enabled cycles, hold after L
        chk("R5 eval length", {7'b0, eval_o[0]}, 8'd1);
        cyc(1);
        chk("R5 hold begins", {7'b0, hold_o[0]}, 8'd1);
        // R1: phase 1 now evaluates
        chk("R1 phase1 eval", {4'b0, eval_o}, 8'b0010);
        cyc(L);
        // R2: recover then idle then evaluate for phase 0
        chk("R2 recover", {6'b0, pc_level_o[1:0]}, 8'b01);
        chk("R2 recover not eval", {7'b0, eval_o[0]}, 8'd0);
        cyc(L);
        chk("R2 idle", {6'b0, pc_level_o[1:0]}, 8'b00);
        cyc(L);
        chk("R2 back to eval", {4'b0, eval_o}, 8'b0001);
        cyc(7);
        // R8: freeze for 10 cycles, then resume mid-interval
        en_i = 1'b0;
        cyc(1);
        snap = pc_level_o;
        cyc(10);
        chk("R8 frozen level", pc_level_o, snap);
        en_i = 1'b1;
        cyc(L - 8);
        chk("R8 resumed eval", {4'b0, eval_o}, 8'b0001);
        cyc(1);
        chk("R8 resumed hold", {4'b0, hold_o}, 8'b0001);
        cyc(13);
        // R9: reset with enable low
        rst_n = 1'b0; en_i = 1'b0;
        cyc(1);
        chk("R9 reset over disable", pc_level_o, 8'b11_01_00_01);
        rst_n = 1'b1;
        // Random mix of enable and reset
        for (int i = 0; i < 4000; i++) begin
            en_i  = ($urandom % 4) != 0;
            rst_n = ($urandom % 100) != 0;
            cyc(1);
        end
        rst_n = 1'b1; en_i = 1'b1;
        cyc(2);
        done = 1'b1;
    end

    initial begin
        for (int t = 0; t < 100000; t++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=done");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule